// File: doc/BRIEF.md
# Register File with Post-Increment Write Port

This block is the architectural register store of a single-cycle load/store datapath. It holds 32 general registers of 32 bits. Two read ports return register contents combinationally. Two write ports update registers on the same rising clock edge.

The first write port is the ordinary result port. It takes an address, data and an enable. The second write port exists so that a load-with-post-increment can retire in one cycle. Its address is the base-register address already presented on read port A. Its data comes from a dedicated adder that adds 4 to the value on read port A. Control asserts the second enable only for that instruction. With that enable low, the block behaves as a plain single-write-port register file.

Register 0 is hardwired to zero.

Top module: `twinWrRegFile`

## Requirements
- R1: A synchronous active-high reset clears every register, so each address afterwards reads as zero on both read ports.
- R2: Both read ports are combinational. A change of read address shows the addressed register in the same cycle. During a write cycle, the reads return the values from before the edge.
- R3: When `wrEnMain` is 1 and `wrAddrMain` is not 0, the addressed register takes `wrDataMain` at the rising edge.
- R4: When `wrEnIncr` is 1, the register addressed by `rdAddrA` takes the pre-edge value of `rdDataA` plus 4 at the rising edge.
- R5: The two write ports may update two different registers on the same edge.
- R6: If both enables are 1 and `wrAddrMain` equals `rdAddrA`, that register takes `wrDataMain`.
- R7: Register 0 always reads as 0. Writes to it from either port are ignored.
- R8: The increment wraps modulo 2^32. A base of 0xFFFFFFFC becomes 0x00000000, with no overflow indication.
- R9: With `wrEnIncr` at 0, only the register addressed by the main port changes. The base register addressed by `rdAddrA` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Read port A address; also the post-increment target |
| rdAddrB | input | 5 | Read port B address |
| rdDataA | output | 32 | Contents of register rdAddrA |
| rdDataB | output | 32 | Contents of register rdAddrB |
| wrEnMain | input | 1 | Main write port enable |
| wrAddrMain | input | 5 | Main write port address |
| wrDataMain | input | 32 | Main write port data |
| wrEnIncr | input | 1 | Post-increment write enable |

## Verification
The bench builds the block with its default parameters: five address bits, 32-bit data and a step of 4. These defaults place all 32 registers, including the hardwired register 0, within reach of the read ports. They also put the wrap from 0xFFFFFFFC to zero at the real word boundary. Directed scenarios cover single and dual writes in one edge, the same-target collision, writes aimed at register 0, and an increment with the second enable held low.

// File: rtl/twinWrRegFile_pkg.sv
package twinWrRegFile_pkg;
  typedef struct packed {
    logic wrMain;
    logic wrIncr;
  } wrStrobe_t;
endpackage

// File: rtl/twinWrRegFile_ctrl.sv
module twinWrRegFile_ctrl
  import twinWrRegFile_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEnMain,
  input  logic [ADDR_W-1:0] wrAddrMain,
  input  logic              wrEnIncr,
  input  logic [ADDR_W-1:0] rdAddrA,
  output wrStrobe_t         strobe
);
  logic mainLive;
  logic incrLive;
  logic sameTarget;

  assign mainLive   = wrEnMain && (wrAddrMain != '0);
  assign incrLive   = wrEnIncr && (rdAddrA != '0);
  assign sameTarget = mainLive && (wrAddrMain == rdAddrA);

  always_comb begin
    strobe        = '0;
    strobe.wrMain = mainLive;
    strobe.wrIncr = incrLive && !sameTarget;
  end

  // R6: never two strobes aimed at the same register
  a_r6_single_owner: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrMain && strobe.wrIncr) |-> (wrAddrMain != rdAddrA));
endmodule

// File: rtl/twinWrRegFile_dpath.sv
module twinWrRegFile_dpath
  import twinWrRegFile_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int INCR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] wrAddrMain,
  input  logic [DATA_W-1:0] wrDataMain,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(INCR_STEP);

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] incData;

  assign rdDataA = regFile[rdAddrA];
  assign rdDataB = regFile[rdAddrB];
  assign incData = rdDataA + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++) begin
        if (strobe.wrMain && (wrAddrMain == ADDR_W'(i)))
          regFile[i] <= wrDataMain;
        else if (strobe.wrIncr && (rdAddrA == ADDR_W'(i)))
          regFile[i] <= incData;
      end
    end
  end

  // R3: main strobe lands its data
  a_r3_main_write: assert property (@(posedge clk) disable iff (rst)
    strobe.wrMain |=> (regFile[$past(wrAddrMain)] == $past(wrDataMain)));

  // R4: increment strobe stores the pre-edge base plus the step
  a_r4_incr_write: assert property (@(posedge clk) disable iff (rst)
    strobe.wrIncr |=> (regFile[$past(rdAddrA)] == $past(rdDataA) + STEP));

  // R6: a main write to the base register leaves the loaded word there
  a_r6_main_wins: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrMain && (wrAddrMain == rdAddrA)) |=> (regFile[$past(rdAddrA)] == $past(wrDataMain)));
endmodule

// File: rtl/twinWrRegFile.sv
module twinWrRegFile
  import twinWrRegFile_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int INCR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEnMain,
  input  logic [ADDR_W-1:0] wrAddrMain,
  input  logic [DATA_W-1:0] wrDataMain,
  input  logic              wrEnIncr
);
  wrStrobe_t strobe;

  twinWrRegFile_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .wrEnMain(wrEnMain), .wrAddrMain(wrAddrMain),
    .wrEnIncr(wrEnIncr), .rdAddrA(rdAddrA),
    .strobe(strobe)
  );

  twinWrRegFile_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INCR_STEP(INCR_STEP)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrAddrMain(wrAddrMain), .wrDataMain(wrDataMain),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  // R7: address zero reads as zero on both ports
  a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
    ((rdAddrA == '0) |-> (rdDataA == '0)) and ((rdAddrB == '0) |-> (rdDataB == '0)));
endmodule

// File: tb/twinWrRegFile_tb_top.sv
module twinWrRegFile_tb_top;
  logic        clk = 0;
  logic        rst;
  logic [4:0]  rdAddrA, rdAddrB, wrAddrMain;
  logic [31:0] rdDataA, rdDataB, wrDataMain;
  logic        wrEnMain, wrEnIncr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  twinWrRegFile dut_i (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEnMain(wrEnMain),
    .wrAddrMain(wrAddrMain), .wrDataMain(wrDataMain), .wrEnIncr(wrEnIncr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readB(input logic [4:0] a, output logic [31:0] v);
    rdAddrB = a;
    #1 v = rdDataB;
  endtask

  task automatic cycle(logic em, logic [4:0] ma, logic [31:0] md, logic ei, logic [4:0] ra);
    @(negedge clk);
    wrEnMain = em; wrAddrMain = ma; wrDataMain = md; wrEnIncr = ei; rdAddrA = ra;
    @(posedge clk);
    #1;
    wrEnMain = 0; wrEnIncr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      readB(5'(i), v);
      check("R1 reset clears", v, 32'h0);
    end
  endtask

  task automatic t_main_write;
    logic [31:0] v;
    cycle(1, 5, 32'hDEAD_0005, 0, 0);
    cycle(1, 6, 32'hBEEF_0006, 0, 0);
    readB(5, v); check("R3 main write r5", v, 32'hDEAD_0005);
    readB(6, v); check("R2 comb read r6", v, 32'hBEEF_0006);
    readB(5, v); check("R2 comb read back r5", v, 32'hDEAD_0005);
  endtask

  task automatic t_incr;
    logic [31:0] v;
    cycle(1, 8, 32'd100, 0, 0);
    @(negedge clk);
    rdAddrA = 8; wrEnIncr = 1; wrEnMain = 1; wrAddrMain = 9; wrDataMain = 32'h0000_AAAA;
    #1 check("R2 pre-edge read", rdDataA, 32'd100);
    @(posedge clk); #1;
    wrEnIncr = 0; wrEnMain = 0;
    readB(8, v); check("R4 base plus 4", v, 32'd104);
    readB(9, v); check("R5 loaded word same edge", v, 32'h0000_AAAA);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    cycle(1, 10, 32'd50, 0, 0);
    cycle(1, 10, 32'h0000_1234, 1, 10);
    readB(10, v); check("R6 main wins", v, 32'h0000_1234);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    cycle(1, 0, 32'hFFFF_FFFF, 0, 0);
    readB(0, v); check("R7 main write to r0 ignored", v, 32'h0);
    cycle(0, 0, 32'h0, 1, 0);
    readB(0, v); check("R7 incr write to r0 ignored", v, 32'h0);
    rdAddrA = 0; #1 check("R7 port A reads zero", rdDataA, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    cycle(1, 11, 32'hFFFF_FFFC, 0, 0);
    cycle(0, 0, 32'h0, 1, 11);
    readB(11, v); check("R8 wrap to zero", v, 32'h0);
    cycle(0, 0, 32'h0, 1, 11);
    readB(11, v); check("R8 after wrap", v, 32'h4);
  endtask

  task automatic t_single;
    logic [31:0] v;
    cycle(1, 12, 32'd77, 0, 0);
    cycle(1, 13, 32'd88, 0, 12);
    readB(12, v); check("R9 base unchanged", v, 32'd77);
    readB(13, v); check("R9 main target written", v, 32'd88);
  endtask

  initial begin
    rst = 1; rdAddrA = 0; rdAddrB = 0; wrAddrMain = 0; wrDataMain = 0;
    wrEnMain = 0; wrEnIncr = 0;
    cycle(1, 3, 32'h1234_5678, 0, 0);
    cycle(0, 0, 0, 0, 0);
    @(negedge clk); rst = 0;
    t_reset();
    t_main_write();
    t_incr();
    t_collision();
    t_zero();
    t_wrap();
    t_single();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule